// File: doc/BRIEF.md
# Supply Fault Output Gating

This block sits between the programmed per-channel driver commands and the output stage of a multi-channel driver. It watches undervoltage and overvoltage flags from two supply monitors. The flags arrive asynchronously and pass through a two-flop synchronizer. An undervoltage on either supply always forces every driver enable low. An overvoltage on either supply forces every enable low only when the overvoltage shutdown enable is 1. With that enable at 0, an overvoltage is only reported.

The programmed commands are never altered by a fault. The gate only masks them, so when the supply recovers the enables return to the programmed pattern without any rewrite. Any fault also sets a sticky supply-fail status bit. That bit stays set after the fault is gone until software pulses the status-reset strobe. A reset strobe given while a fault is still present leaves the bit set.

Top module: `supply_guard`

## Requirements
- R1: While `rst_n` is low, `drv_en` is all zeros and `supply_fail` is 0.
- R2: With no fault seen by the synchronizer, `drv_en` equals the `cmd` value sampled at the previous rising clock edge.
- R3: An undervoltage flag (bit 0 or bit 1 of `uv_flag` equal to 1) forces `drv_en` to all zeros whatever `ov_shdn_en` and `cmd` are. The outputs go low at the third rising edge after the flag is applied.
- R4: An overvoltage flag (either bit of `ov_flag` equal to 1) forces `drv_en` to all zeros when `ov_shdn_en` is 1.
- R5: An overvoltage flag with `ov_shdn_en` at 0 leaves `drv_en` following `cmd`, and it still sets `supply_fail`.
- R6: Any undervoltage or overvoltage flag sets `supply_fail` at the third rising edge after the flag is applied.
- R7: `supply_fail` stays at 1 after every flag is gone. It clears at the rising edge that samples `status_clr` at 1, provided no fault is present.
- R8: A `status_clr` pulse sampled while a synchronized fault is present leaves `supply_fail` at 1.
- R9: Once all flags drop, `drv_en` returns to the current `cmd` pattern at the third rising edge, with no new write to `cmd`.
- R10: The fault flags pass through two flops. A flag change has no effect on either output at the first and second rising edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uv_flag | input | 2 | Undervoltage flags, one per supply (asynchronous) |
| ov_flag | input | 2 | Overvoltage flags, one per supply (asynchronous) |
| ov_shdn_en | input | 1 | 1: an overvoltage shuts the outputs off |
| status_clr | input | 1 | Status-reset strobe for `supply_fail` |
| cmd | input | NUM_CH | Programmed on/off command per channel |
| drv_en | output | NUM_CH | Gated, registered driver enables |
| supply_fail | output | 1 | Sticky supply-fail status |

## Verification
A change on `cmd`, `ov_shdn_en` or `status_clr` is due on the outputs at the first rising edge that samples it. A change on a fault flag is due at the third rising edge: two synchronizer flops and then the output register. The bench drives each step on a falling edge and waits for one rising edge. It keeps the last two flag values in its own two-entry history, so each expected value pairs the current command inputs with the flags from two steps earlier. It compares on the next falling edge. The directed cases hold a flag edge and check the outputs at the first, second and third edges after it, which confirms both the delay and the lack of any earlier reaction.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int NUM_SUPPLY = 2;

  // Shutdown rule: undervoltage always, overvoltage only when enabled.
  function automatic logic shut_rule(input logic uv_any, input logic ov_any,
                                     input logic ov_en);
    return uv_any | (ov_any & ov_en);
  endfunction

  // Any monitor reporting a breach counts as a fault for the status bit.
  function automatic logic fault_rule(input logic uv_any, input logic ov_any);
    return uv_any | ov_any;
  endfunction
endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[gi] <= '0;
        else if (gi == 0) stg[gi] <= d;
        else stg[gi] <= stg[(gi == 0) ? 0 : gi - 1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sg_fault_combine.sv
module sg_fault_combine
  import sg_pkg::*;
(
  input  logic [NUM_SUPPLY-1:0] uv_s,
  input  logic [NUM_SUPPLY-1:0] ov_s,
  input  logic                  ov_en,
  output logic                  uv_any,
  output logic                  ov_any,
  output logic                  fault_any,
  output logic                  shut
);
  always_comb begin
    uv_any    = |uv_s;
    ov_any    = |ov_s;
    fault_any = fault_rule(uv_any, ov_any);
    shut      = shut_rule(uv_any, ov_any, ov_en);
  end
endmodule

// File: rtl/sg_status_latch.sv
module sg_status_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_any,
  input  logic clr,
  output logic status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status <= 1'b0;
    else if (fault_any) status <= 1'b1;
    else if (clr)       status <= 1'b0;
  end

  // R6
  fault_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_any |=> status);
  // R8
  clr_blocked_by_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_any && clr) |=> status);
  // R7
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !clr) |=> status);
  // R7
  status_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fault_any) |=> !status);
endmodule

// File: rtl/sg_out_gate.sv
module sg_out_gate #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cmd,
  input  logic              shut,
  output logic [NUM_CH-1:0] drv_en
);
  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drv_en[ch] <= 1'b0;
        else        drv_en[ch] <= cmd[ch] & ~shut;
      end
    end
  endgenerate
endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import sg_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SUPPLY-1:0] uv_flag,
  input  logic [NUM_SUPPLY-1:0] ov_flag,
  input  logic                  ov_shdn_en,
  input  logic                  status_clr,
  input  logic [NUM_CH-1:0]     cmd,
  output logic [NUM_CH-1:0]     drv_en,
  output logic                  supply_fail
);
  localparam int FLAG_W = 2 * NUM_SUPPLY;

  logic [FLAG_W-1:0]     flags_s;
  logic [NUM_SUPPLY-1:0] uv_s, ov_s;
  logic uv_any, ov_any, fault_any, shut;

  sg_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ov_flag, uv_flag}), .q(flags_s));

  assign uv_s = flags_s[NUM_SUPPLY-1:0];
  assign ov_s = flags_s[FLAG_W-1:NUM_SUPPLY];

  sg_fault_combine u_comb (
    .uv_s(uv_s), .ov_s(ov_s), .ov_en(ov_shdn_en),
    .uv_any(uv_any), .ov_any(ov_any), .fault_any(fault_any), .shut(shut));

  sg_status_latch u_stat (
    .clk(clk), .rst_n(rst_n), .fault_any(fault_any), .clr(status_clr),
    .status(supply_fail));

  sg_out_gate #(.NUM_CH(NUM_CH)) u_gate (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .shut(shut), .drv_en(drv_en));

  // R3
  uv_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_any |=> (drv_en == '0));
  // R4
  ov_enabled_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_any && ov_shdn_en) |=> (drv_en == '0));
  // R5
  ov_report_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_any && !ov_shdn_en && !uv_any) |=> (drv_en == $past(cmd)));
  // R2
  follow_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_any && !ov_any) |=> (drv_en == $past(cmd)));
endmodule

// File: tb/supply_guard_tb_top.sv
module supply_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic           rst_n = 1'b0;
  logic [1:0]     uv_flag = '0, ov_flag = '0;
  logic           ov_shdn_en = 1'b0, status_clr = 1'b0;
  logic [NCH-1:0] cmd = '0;
  logic [NCH-1:0] drv_en;
  logic           supply_fail;

  supply_guard #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .ov_flag(ov_flag),
    .ov_shdn_en(ov_shdn_en), .status_clr(status_clr), .cmd(cmd),
    .drv_en(drv_en), .supply_fail(supply_fail));

  int   errors = 0, checks = 0;
  logic done = 1'b0;

  // Bench model: flags applied two steps back reach the output this step.
  logic [1:0] uv_h1 = '0, uv_h2 = '0, ov_h1 = '0, ov_h2 = '0;
  logic       st_exp = 1'b0;

  function automatic logic [NCH-1:0] exp_drv(input logic [NCH-1:0] c,
      input logic [1:0] uv, input logic [1:0] ov, input logic en);
    if (uv != 2'b00) return '0;
    if (ov != 2'b00 && en) return '0;
    return c;
  endfunction

  task automatic chk(input string tag, input logic [NCH-1:0] act,
                     input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; leaves at the next falling edge after checking.
  task automatic step(input logic [1:0] uv, input logic [1:0] ov,
                      input logic en, input logic clr,
                      input logic [NCH-1:0] c, input string tag);
    logic [NCH-1:0] e;
    string td, ts;
    uv_flag = uv; ov_flag = ov; ov_shdn_en = en; status_clr = clr; cmd = c;
    @(posedge clk);
    e = exp_drv(c, uv_h2, ov_h2, en);
    if (uv_h2 != 0 || ov_h2 != 0) st_exp = 1'b1;
    else if (clr) st_exp = 1'b0;
    if (tag != "") td = tag;
    else if (uv_h2 != 0) td = "R3";
    else if (ov_h2 != 0 && en) td = "R4";
    else if (ov_h2 != 0) td = "R5";
    else td = "R2";
    if (tag != "") ts = tag;
    else if ((uv_h2 != 0 || ov_h2 != 0) && clr) ts = "R8";
    else if (uv_h2 != 0 || ov_h2 != 0) ts = "R6";
    else ts = "R7";
    uv_h2 = uv_h1; uv_h1 = uv; ov_h2 = ov_h1; ov_h1 = ov;
    @(negedge clk);
    chk({td, " drv_en"}, drv_en, e);
    chk({ts, " supply_fail"}, {{(NCH-1){1'b0}}, supply_fail},
        {{(NCH-1){1'b0}}, st_exp});
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    cmd = 8'hFF; uv_flag = 2'b11;
    @(negedge clk);
    // R1: reset state
    chk("R1 drv_en", drv_en, '0);
    chk("R1 supply_fail", {7'b0, supply_fail}, 8'h00);
    uv_flag = '0;
    rst_n = 1'b1;

    // R10: flag edge must not show at edges one and two, shows at three
    step(2'b00, 2'b00, 1'b0, 1'b0, 8'hA5, "R2");
    step(2'b00, 2'b00, 1'b0, 1'b0, 8'hA5, "R2");
    step(2'b10, 2'b00, 1'b0, 1'b0, 8'hA5, "R10");
    step(2'b10, 2'b00, 1'b0, 1'b0, 8'hA5, "R10");
    step(2'b10, 2'b00, 1'b0, 1'b0, 8'hA5, "R3");
    // R8: clear during active fault
    step(2'b10, 2'b00, 1'b0, 1'b1, 8'h3C, "R8");
    // R9: recovery without rewriting cmd
    step(2'b00, 2'b00, 1'b0, 1'b0, 8'h3C, "R9");
    step(2'b00, 2'b00, 1'b0, 1'b0, 8'h3C, "R9");
    step(2'b00, 2'b00, 1'b0, 1'b0, 8'h3C, "R9");
    // R7: sticky, then cleared
    step(2'b00, 2'b00, 1'b0, 1'b0, 8'h3C, "R7");
    step(2'b00, 2'b00, 1'b0, 1'b1, 8'h3C, "R7");
    // R5: overvoltage with shutdown disabled
    for (int i = 0; i < 4; i++) step(2'b00, 2'b01, 1'b0, 1'b0, 8'h96, "");
    // R4: overvoltage with shutdown enabled
    for (int i = 0; i < 4; i++) step(2'b00, 2'b10, 1'b1, 1'b0, 8'h5A, "");
    for (int i = 0; i < 4; i++) step(2'b00, 2'b00, 1'b1, 1'b1, 8'h5A, "");

    // Random phase
    for (int i = 0; i < 600; i++) begin
      logic [1:0] u, o;
      u = ($urandom % 6 == 0) ? 2'($urandom) : 2'b00;
      o = ($urandom % 5 == 0) ? 2'($urandom) : 2'b00;
      step(u, o, 1'($urandom), ($urandom % 4 == 0), 8'($urandom), "");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule